// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

The block holds a small set of event counters that a cache controller uses for measurement. Each counter has its own configuration word, made of an event code and a clear-on-read flag. Every clock cycle the block samples a vector of single-cycle event strobes, one bit per event code, such as hits, misses, victim hits, tag probes and request pulses. A counter adds one in any cycle in which the strobe for its chosen code is high. Code 0 is special: it counts every clock cycle.

Software reaches the bank through a simple valid-qualified register port. One request bit picks either the configuration word or the count of the addressed counter, and a read returns its data one cycle later. If a counter's clear-on-read flag is set, reading its count also resets that count in the same cycle. Rewriting the configuration never disturbs the accumulated count. The counters wrap around on overflow and do not saturate.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every count is zero, and every configuration word reads as zero (event code 0, clear-on-read flag off). A count read issued on the first clock edge after reset returns 0.
- R2: `req_idx` selects one of four counters (0 to 3). `req_cfg`=1 addresses the configuration word, whose layout is bits [7:0] = event code and bit 8 = clear-on-read flag. A configuration read returns exactly those 9 bits, zero-extended.
- R3: A counter with event code 0 adds one on every clock edge, whatever the strobes are.
- R4: A counter with event code k (1 to 53) adds one on each clock edge at which `ev_strobe[k]` is high. Other strobe bits have no effect on it.
- R5: A counter whose event code is 54 or above never changes, except when a clear-on-read read clears it.
- R6: `rsp_valid` is high exactly in the cycle after a read request (`req_valid`=1, `req_write`=0). `rsp_data` then holds the addressed value as it was before the request's clock edge.
- R7: A count read of a counter whose clear-on-read flag is set returns the value before the edge. The counter becomes 0 after that edge, or 1 if its event fired in the same cycle.
- R8: A count read of a counter whose clear-on-read flag is off leaves the count unchanged.
- R9: Writing a configuration word (`req_write`=1, `req_cfg`=1) does not change any count. The new code takes effect from the next clock edge.
- R10: A count that overflows wraps to zero and keeps counting.
- R11: A write with `req_cfg`=0 (count address) has no effect on any count or configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_strobe | input | NUM_EVENTS (54) | Event strobes, bit k belongs to event code k (bit 0 unused) |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 1 | 1 = configuration word, 0 = count |
| req_idx | input | IDX_W (2) | Counter index |
| req_wdata | input | 9 | Write data: [7:0] event code, [8] clear-on-read |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | CNT_W (64) | Read data |

## Verification
Several rules are checked by assertions on every cycle. Each count either holds or steps by its selected strobe, modulo 2^CNT_W. A clear-on-read read leaves only that cycle's increment. Code 0 always fires, and codes of 54 or more never do. At most one counter is read per cycle, and read responses come back after exactly one cycle. Other behaviours can only be shown by the bench's scenarios: the values returned by reads, the configuration readback layout, writes to the count address being ignored, and the actual wrap of a count. The wrap is exercised on a second instance with 16-bit counters.

// File: rtl/pcb_pkg.sv
// Shared constants and types for the performance counter bank.
// Assumes event codes fit in EVT_CODE_W bits.
package pcb_pkg;

    localparam int EVT_CODE_W      = 8;
    localparam int NUM_EVENT_CODES = 54;

    // Named low event codes; code 0 is the free-running cycle count.
    typedef enum logic [EVT_CODE_W-1:0] {
        EV_CYCLES    = 8'd0,
        EV_INSN_MISS = 8'd1,
        EV_INSN_HIT  = 8'd2,
        EV_DATA_MISS = 8'd3,
        EV_DATA_HIT  = 8'd4,
        EV_ANY_MISS  = 8'd5,
        EV_ANY_HIT   = 8'd6
    } ev_code_e;

    // Per-counter configuration word, as laid out on the write data bus.
    typedef struct packed {
        logic                  clr_on_rd;
        logic [EVT_CODE_W-1:0] evt;
    } ctr_cfg_t;

    localparam int CFG_W = $bits(ctr_cfg_t);

endpackage

// File: rtl/pcb_event_sel.sv
// Event selector: turns a counter's event code into a single increment strobe.
// Code 0 always fires. Codes 1..NUM_EVENTS-1 pick their strobe bit.
// Codes at or above NUM_EVENTS never fire.
// Assumes NUM_EVENTS <= 2**EVT_CODE_W.
module pcb_event_sel
    import pcb_pkg::*;
#(
    parameter int NUM_EVENTS = NUM_EVENT_CODES
) (
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic [EVT_CODE_W-1:0] sel,
    output logic                  hit
);

    localparam int CODES = 1 << EVT_CODE_W;

    logic [CODES-1:0] ev_ext;

    // Zero-extend the strobes so codes beyond the last event read as idle.
    assign ev_ext = {{(CODES-NUM_EVENTS){1'b0}}, ev_strobe};

    // Pick the selected strobe, forcing the cycle code high.
    always_comb begin
        if (sel == EV_CYCLES) begin
            hit = 1'b1;
        end else begin
            hit = ev_ext[sel];
        end
    end

endmodule

// File: rtl/pcb_counter.sv
// One counter slice: configuration register plus a wrapping CNT_W-bit count.
// A count read with clear-on-read set zeroes the count on the same edge.
// An event in that cycle then leaves the count at 1.
// Assumes a configuration write and a count read never coincide.
// The register port issues one request per cycle.
module pcb_counter
    import pcb_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  ctr_cfg_t         cfg_wdata,
    input  logic             cnt_rd,
    input  logic             hit,
    output ctr_cfg_t         cfg_q,
    output logic [CNT_W-1:0] cnt_q
);

    logic             clr;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_nxt;

    // Hold the configuration word; only a configuration write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Work out the next count: optional clear, then the increment, wrapping.
    always_comb begin
        clr     = cnt_rd & cfg_q.clr_on_rd;
        base    = clr ? '0 : cnt_q;
        cnt_nxt = base + CNT_W'(hit);
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/pcb_regport.sv
// Register port: decodes one request per cycle into per-counter strobes.
// It also registers the read response one cycle later.
// A count read returns the value before the request edge.
// A configuration read returns the 9-bit word zero-extended.
// An index beyond NUM_CTRS decodes to nothing and reads as zero.
module pcb_regport
    import pcb_pkg::*;
#(
    parameter int NUM_CTRS = 4,
    parameter int CNT_W    = 64,
    parameter int IDX_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic                            req_cfg,
    input  logic [IDX_W-1:0]                req_idx,
    input  logic [NUM_CTRS-1:0][CNT_W-1:0]  cnt_vec,
    input  ctr_cfg_t [NUM_CTRS-1:0]         cfg_vec,
    output logic [NUM_CTRS-1:0]             cfg_we_vec,
    output logic [NUM_CTRS-1:0]             cnt_rd_vec,
    output logic                            rsp_valid,
    output logic [CNT_W-1:0]                rsp_data
);

    logic             is_read;
    logic [CNT_W-1:0] rd_mux;

    assign is_read = req_valid & ~req_write;

    // Decode the index into one strobe per counter.
    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_dec
        assign cfg_we_vec[g] = req_valid & req_write & req_cfg & (req_idx == IDX_W'(g));
        assign cnt_rd_vec[g] = is_read & ~req_cfg & (req_idx == IDX_W'(g));
    end

    // Select the readback value for the addressed counter.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CTRS; i++) begin
            if (req_idx == IDX_W'(i)) begin
                rd_mux = req_cfg ? CNT_W'(cfg_vec[i]) : cnt_vec[i];
            end
        end
    end

    // Register the response valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= is_read;
        end
    end

    // Capture the read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (is_read) begin
            rsp_data <= rd_mux;
        end
    end

endmodule

// File: rtl/perf_counter_bank.sv
// Top of the performance counter bank: NUM_CTRS counter slices, each with its
// own event selector, behind one valid-qualified register port.
// Assumes CNT_W >= CFG_W so a configuration word fits in the read data.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTRS   = 4,
    parameter int CNT_W      = 64,
    parameter int NUM_EVENTS = NUM_EVENT_CODES,
    localparam int IDX_W     = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_cfg,
    input  logic [IDX_W-1:0]      req_idx,
    input  logic [CFG_W-1:0]      req_wdata,
    output logic                  rsp_valid,
    output logic [CNT_W-1:0]      rsp_data
);

    logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_vec;
    ctr_cfg_t [NUM_CTRS-1:0]        cfg_vec;
    logic [NUM_CTRS-1:0]            cfg_we_vec;
    logic [NUM_CTRS-1:0]            cnt_rd_vec;
    logic [NUM_CTRS-1:0]            hit_vec;
    ctr_cfg_t                       cfg_wdata;

    assign cfg_wdata = ctr_cfg_t'(req_wdata);

    pcb_regport #(
        .NUM_CTRS (NUM_CTRS),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_cfg    (req_cfg),
        .req_idx    (req_idx),
        .cnt_vec    (cnt_vec),
        .cfg_vec    (cfg_vec),
        .cfg_we_vec (cfg_we_vec),
        .cnt_rd_vec (cnt_rd_vec),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    // One event selector and one counter per slice.
    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
        pcb_event_sel #(
            .NUM_EVENTS (NUM_EVENTS)
        ) u_sel (
            .ev_strobe (ev_strobe),
            .sel       (cfg_vec[g].evt),
            .hit       (hit_vec[g])
        );

        pcb_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we_vec[g]),
            .cfg_wdata (cfg_wdata),
            .cnt_rd    (cnt_rd_vec[g]),
            .hit       (hit_vec[g]),
            .cfg_q     (cfg_vec[g]),
            .cnt_q     (cnt_vec[g])
        );
    end

endmodule

// File: rtl/pcb_checker.sv
// Assertion checker for perf_counter_bank, attached with bind below.
// It watches the slice counts, strobes and read decode against the port.
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int NUM_CTRS   = 4,
    parameter int CNT_W      = 64,
    parameter int NUM_EVENTS = NUM_EVENT_CODES
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_write,
    input logic                           rsp_valid,
    input logic [NUM_CTRS-1:0][CNT_W-1:0] cnt_vec,
    input ctr_cfg_t [NUM_CTRS-1:0]        cfg_vec,
    input logic [NUM_CTRS-1:0]            cnt_rd_vec,
    input logic [NUM_CTRS-1:0]            hit_vec
);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid && !req_write))); // R6

    AST_ONE_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_rd_vec)); // R2

    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_chk
        AST_STEP_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cnt_rd_vec[g] && cfg_vec[g].clr_on_rd))
            |-> (cnt_vec[g] == $past(cnt_vec[g]) + CNT_W'($past(hit_vec[g])))); // R10

        AST_COR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cnt_rd_vec[g] && cfg_vec[g].clr_on_rd))
            |-> (cnt_vec[g] == CNT_W'($past(hit_vec[g])))); // R7

        AST_CYCLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_vec[g].evt == EV_CYCLES) |-> hit_vec[g]); // R3

        AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(cfg_vec[g].evt) >= NUM_EVENTS) |-> !hit_vec[g]); // R5
    end

endmodule

bind perf_counter_bank pcb_checker #(
    .NUM_CTRS   (NUM_CTRS),
    .CNT_W      (CNT_W),
    .NUM_EVENTS (NUM_EVENTS)
) u_pcb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .cnt_vec    (cnt_vec),
    .cfg_vec    (cfg_vec),
    .cnt_rd_vec (cnt_rd_vec),
    .hit_vec    (hit_vec)
);

// File: tb/test_perf_counter_bank.sv
// Bench for perf_counter_bank: a reference model in bench variables, directed
// corner cases, then seeded random traffic. A 16-bit instance proves wrap.
module test_perf_counter_bank;

    localparam int NEV = 54;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NEV-1:0] ev_strobe = '0;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic           req_cfg = 1'b0;
    logic [1:0]     req_idx = '0;
    logic [8:0]     req_wdata = '0;
    logic           rsp_valid;
    logic [63:0]    rsp_data;

    logic           n_valid = 1'b0;
    logic           n_write = 1'b0;
    logic           n_cfg = 1'b0;
    logic [8:0]     n_wdata = '0;
    logic           n_rsp_valid;
    logic [15:0]    n_rsp_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt [4];
    logic [7:0]  m_evt [4];
    logic        m_cor [4];

    always #2 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_strobe (ev_strobe),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cfg   (req_cfg),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    perf_counter_bank #(.CNT_W(16)) i_perf_counter_bank_narrow (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_strobe ('0),
        .req_valid (n_valid),
        .req_write (n_write),
        .req_cfg   (n_cfg),
        .req_idx   (2'd0),
        .req_wdata (n_wdata),
        .rsp_valid (n_rsp_valid),
        .rsp_data  (n_rsp_data)
    );

    function automatic logic f_hit(input logic [7:0] evt, input logic [NEV-1:0] ev);
        if (evt == 8'd0) return 1'b1;
        if (int'(evt) < NEV) return ev[evt];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock of traffic, with the model updated and the response checked.
    task automatic do_cycle(input logic v, input logic w, input logic c, input logic [1:0] idx,
                            input logic [8:0] wd, input logic [NEV-1:0] ev, input string tag);
        logic        rd;
        logic [63:0] exp;
        @(negedge clk);
        req_valid = v; req_write = w; req_cfg = c; req_idx = idx; req_wdata = wd; ev_strobe = ev;
        @(posedge clk);
        rd  = v && !w;
        exp = '0;
        if (rd) exp = c ? {55'd0, m_cor[idx], m_evt[idx]} : m_cnt[idx];
        for (int k = 0; k < 4; k++) begin
            if (rd && !c && idx == 2'(k) && m_cor[k]) m_cnt[k] = '0;
            m_cnt[k] = m_cnt[k] + 64'(f_hit(m_evt[k], ev));
        end
        if (v && w && c) begin
            m_evt[idx] = wd[7:0];
            m_cor[idx] = wd[8];
        end
        #1;
        check({tag, " (R6 valid)"}, {63'd0, rsp_valid}, {63'd0, rd});
        if (rd) check(tag, rsp_data, exp);
    endtask

    task automatic rd_cnt(input logic [1:0] idx, input logic [NEV-1:0] ev, input string tag);
        do_cycle(1'b1, 1'b0, 1'b0, idx, 9'd0, ev, tag);
    endtask

    task automatic rd_cfg(input logic [1:0] idx, input string tag);
        do_cycle(1'b1, 1'b0, 1'b1, idx, 9'd0, '0, tag);
    endtask

    task automatic wr_cfg(input logic [1:0] idx, input logic [7:0] evt, input logic cor, input string tag);
        do_cycle(1'b1, 1'b1, 1'b1, idx, {cor, evt}, '0, tag);
    endtask

    task automatic idle(input int n, input logic [NEV-1:0] ev);
        for (int i = 0; i < n; i++) do_cycle(1'b0, 1'b0, 1'b0, 2'd0, 9'd0, ev, "idle");
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 195000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NEV-1:0] pat;
        int unsigned    seed;
        for (int k = 0; k < 4; k++) begin
            m_cnt[k] = '0; m_evt[k] = '0; m_cor[k] = 1'b0;
        end
        seed = 32'h5eed_2024;
        void'($urandom(seed));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: first read after reset and config readback.
        rd_cnt(2'd0, '0, "R1 count after reset");
        for (int k = 0; k < 4; k++) rd_cfg(2'(k), "R1 config after reset");

        // R2: config layout, upper fields only.
        wr_cfg(2'd1, 8'd4, 1'b0, "R2 write");
        rd_cfg(2'd1, "R2 config readback");
        wr_cfg(2'd2, 8'd53, 1'b1, "R2 write");
        rd_cfg(2'd2, "R2 config readback cor");

        // R3: code 0 counts with no strobes.
        idle(7, '0);
        rd_cnt(2'd0, '0, "R3 cycle count");

        // R9: config write keeps count; ctr0 already counts cycles.
        wr_cfg(2'd0, 8'd3, 1'b0, "R9 write");
        rd_cnt(2'd0, '0, "R9 count kept");

        // R4: ctr2 code 53 (cor on) counts only bit 53.
        rd_cnt(2'd2, '0, "R4 clear first");
        pat = '0; pat[53] = 1'b1;
        idle(5, pat);
        pat = '0; pat[52] = 1'b1;
        idle(4, pat);
        rd_cnt(2'd2, '0, "R4 code 53 count");

        // R5: codes 54 and 255 never count.
        wr_cfg(2'd3, 8'd54, 1'b0, "R5 write");
        rd_cnt(2'd3, '1, "R5 baseline");
        idle(6, '1);
        rd_cnt(2'd3, '1, "R5 code 54 held");
        wr_cfg(2'd3, 8'd255, 1'b0, "R5 write");
        idle(3, '1);
        rd_cnt(2'd3, '1, "R5 code 255 held");

        // R7: clear-on-read with a coincident event gives 1.
        wr_cfg(2'd0, 8'd6, 1'b1, "R7 write");
        idle(4, 54'd1 << 6);
        rd_cnt(2'd0, 54'd1 << 6, "R7 read returns old value");
        rd_cnt(2'd0, '0, "R7 left at one");
        rd_cnt(2'd0, '0, "R7 cleared to zero");

        // R8: no clearing without the flag.
        idle(3, 54'd1 << 4);
        rd_cnt(2'd1, 54'd1 << 4, "R8 read");
        rd_cnt(2'd1, 54'd1 << 4, "R8 read again kept");

        // R11: count-address writes do nothing.
        do_cycle(1'b1, 1'b1, 1'b0, 2'd1, 9'h1ff, '0, "R11 write ignored");
        rd_cfg(2'd1, "R11 config untouched");
        rd_cnt(2'd1, '0, "R11 count untouched");

        // Seeded random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            logic       v, w, c, cor;
            logic [1:0] idx;
            logic [7:0] evt;
            v   = 1'($urandom % 2);
            w   = (($urandom % 3) == 0);
            c   = 1'($urandom % 2);
            idx = 2'($urandom % 4);
            evt = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 60);
            cor = 1'($urandom % 2);
            pat = NEV'({$urandom, $urandom} & {$urandom, $urandom});
            do_cycle(v, w, c, idx, {cor, evt}, pat, "R4 R7 random");
        end
        idle(1, '0);

        // R10: 16-bit instance, code 0 with clear-on-read, 65543 edges apart.
        @(negedge clk);
        n_valid = 1'b1; n_write = 1'b1; n_cfg = 1'b1; n_wdata = 9'h100;
        @(negedge clk);
        n_write = 1'b0; n_cfg = 1'b0;
        @(negedge clk);
        n_valid = 1'b0;
        repeat (65542) @(negedge clk);
        n_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R10 wrap valid", {63'd0, n_rsp_valid}, 64'd1);
        check("R10 wrap value", {48'd0, n_rsp_data}, 64'd7);
        @(negedge clk);
        n_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule